// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a chain of command nodes held in system memory and passes each node's payload words, in order, to a downstream command consumer. Every node starts with one header word. The header carries an 8-bit payload length in its top byte and a 24-bit next-node pointer in its low bits. The payload words follow the header directly. A next pointer of all ones marks the last node in the chain.

All memory traffic goes through one request/grant port with read data returned later. Payload words leave on a valid/ready stream. A malformed chain could point back into itself. To guard against this, the walker sets a spare header bit on each node it passes. If it later reads a header that already carries that bit, it stops and reports a loop. After the walk ends, a second pass starts again from the first node and rewrites every marked header with the bit cleared. The chain is then back in its original state.

A one-cycle done pulse ends each run. It comes with the number of nodes visited, a cost estimate and a loop flag.

Top module: `chain_walker`

## Requirements
- R1: The walk begins at `start_addr_i` (24 bits). If that value is 0xFFFFFF, the run ends with done, a node count of 0, no loop flag and no memory access at all.
- R2: A pointer selects the memory byte address given by its bits 20:0. A header's bits 23:0 are the next pointer and its bits 31:24 are the payload length in words. While a request waits for grant, its address and direction stay stable.
- R3: The payload words are read from the header address plus 4, plus 8, and so on. They appear on the output stream in that order. `out_data_o` holds steady while `out_valid_o` is high and `out_ready_i` is low.
- R4: A node whose length is 0 puts no word on the output stream, but it is still counted as visited.
- R5: A header whose next pointer is not 0xFFFFFF and whose bit 23 is clear is read and then written back with bit 23 set. The write goes to the same address, and no other access comes between the read and the write.
- R6: A header whose next pointer is 0xFFFFFF is the tail. Its payload is sent and it is counted. It is never written, and the walk ends after it.
- R7: A non-tail header that is read with bit 23 already set ends the walk with the loop flag raised. That node is not counted and none of its payload is sent.
- R8: After the walk, every header that was marked is read again and written back with only bit 23 cleared. When done pulses, all headers equal their values from before the run.
- R9: The cost estimate is the sum of 5 plus the length field over every header read during the walk, including a header that triggers loop detection.
- R10: `done_o` is high for exactly one cycle. The node count, cost estimate and loop flag are valid in that cycle and stay unchanged until the next accepted start.
- R11: A start pulse that arrives while `busy_o` is high is ignored. The run in progress gives the same results as it would without the pulse.
- R12: After reset, `busy_o`, `done_o`, `out_valid_o` and `mem_req_o` are low. Whenever the walker is idle, it neither requests memory nor offers output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| start_addr_i | input | 24 | First node pointer |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| node_cnt_o | output | 20 | Nodes visited in the last run |
| cyc_est_o | output | 32 | Cost estimate of the last run |
| loop_o | output | 1 | Last run ended on a revisited node |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 21 | Byte address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| out_valid_o | output | 1 | Payload word valid |
| out_data_o | output | 32 | Payload word |
| out_ready_i | input | 1 | Consumer accepts the word |

## Verification
The hardest case to reach is a loop hit. It requires a header that the walker itself marked earlier in the same run. The cleanup pass must then restore exactly the marked prefix, even though the node that closed the loop was read but never counted. The stimulus builds a two-node ring in the bench memory. It checks the count, the cost (which includes the third header read) and the loop flag, and then reads back both headers after done. Grants stall one cycle in three and the consumer's ready toggles every cycle, so every read-modify-write pair and every held payload word also runs under backpressure.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;

  localparam int unsigned CW_PTR_W   = 24;
  localparam int unsigned CW_MADDR_W = 21;
  localparam int unsigned CW_DATA_W  = 32;
  localparam int unsigned CW_LEN_W   = 8;
  localparam int unsigned CW_CNT_W   = 20;
  localparam int unsigned CW_CYC_W   = 32;
  localparam int unsigned CW_CYC_BASE = 5;

  typedef enum logic [3:0] {
    S_IDLE,
    S_NEXT,
    S_HRD,
    S_HWAIT,
    S_HWR,
    S_PRD,
    S_PWAIT,
    S_POUT,
    S_CSTART,
    S_CRD,
    S_CWAIT,
    S_CWR,
    S_DONE
  } cw_state_e;

endpackage

// File: rtl/chain_walker_stats.sv
module chain_walker_stats #(
  parameter int unsigned LEN_W    = chain_walker_pkg::CW_LEN_W,
  parameter int unsigned CNT_W    = chain_walker_pkg::CW_CNT_W,
  parameter int unsigned CYC_W    = chain_walker_pkg::CW_CYC_W,
  parameter int unsigned CYC_BASE = chain_walker_pkg::CW_CYC_BASE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hdr_en,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic             node_inc,
  input  logic             mark_inc,
  input  logic             loop_set,
  output logic [CNT_W-1:0] node_cnt,
  output logic [CNT_W-1:0] mark_cnt,
  output logic [CYC_W-1:0] cyc_est,
  output logic             loop_flag
);

  localparam logic [CYC_W-1:0] BASE = CYC_W'(CYC_BASE);

  logic [CNT_W-1:0] node_cnt_n, mark_cnt_n;
  logic [CYC_W-1:0] cyc_est_n;
  logic             loop_flag_n;
  logic             upd_en;

  assign upd_en = clr | hdr_en | node_inc | mark_inc | loop_set;

  always_comb begin
    node_cnt_n  = node_cnt;
    mark_cnt_n  = mark_cnt;
    cyc_est_n   = cyc_est;
    loop_flag_n = loop_flag;
    if (clr) begin
      node_cnt_n  = '0;
      mark_cnt_n  = '0;
      cyc_est_n   = '0;
      loop_flag_n = 1'b0;
    end else begin
      if (hdr_en)   cyc_est_n  = cyc_est + BASE + CYC_W'(hdr_len);
      if (node_inc) node_cnt_n = node_cnt + 1'b1;
      if (mark_inc) mark_cnt_n = mark_cnt + 1'b1;
      if (loop_set) loop_flag_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_cnt  <= '0;
      mark_cnt  <= '0;
      cyc_est   <= '0;
      loop_flag <= 1'b0;
    end else if (upd_en) begin
      node_cnt  <= node_cnt_n;
      mark_cnt  <= mark_cnt_n;
      cyc_est   <= cyc_est_n;
      loop_flag <= loop_flag_n;
    end
  end

endmodule

// File: rtl/chain_walker_outreg.sv
module chain_walker_outreg #(
  parameter int unsigned DATA_W = chain_walker_pkg::CW_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              taken
);

  logic valid_n;

  assign taken = valid & ready;

  always_comb begin
    valid_n = valid;
    if (taken) valid_n = 1'b0;
    if (load)  valid_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data <= '0;
    else if (load) data <= load_data;
  end

endmodule

// File: rtl/chain_walker_ctrl.sv
module chain_walker_ctrl
  import chain_walker_pkg::*;
#(
  parameter int unsigned PTR_W   = CW_PTR_W,
  parameter int unsigned MADDR_W = CW_MADDR_W,
  parameter int unsigned DATA_W  = CW_DATA_W,
  parameter int unsigned LEN_W   = CW_LEN_W,
  parameter int unsigned CNT_W   = CW_CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [PTR_W-1:0]   start_addr,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               out_taken,
  input  logic [CNT_W-1:0]   mark_cnt,
  output logic               mem_req,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               load_out,
  output logic               stat_clr,
  output logic               hdr_en,
  output logic [LEN_W-1:0]   hdr_len_o,
  output logic               node_inc,
  output logic               mark_inc,
  output logic               loop_set,
  output logic               busy,
  output logic               done
);

  localparam logic [PTR_W-1:0]   TERM     = {PTR_W{1'b1}};
  localparam int unsigned        MARK_BIT = PTR_W - 1;
  localparam logic [DATA_W-1:0]  MARK     = DATA_W'(1) << MARK_BIT;
  localparam logic [MADDR_W-1:0] STEP     = MADDR_W'(DATA_W / 8);

  cw_state_e          state, state_n;
  logic [PTR_W-1:0]   ptr, ptr_n, start_q, start_n;
  logic [DATA_W-1:0]  hdr, hdr_n;
  logic [MADDR_W-1:0] paddr, paddr_n;
  logic [LEN_W-1:0]   rem, rem_n;
  logic [CNT_W-1:0]   left, left_n;

  logic [MADDR_W-1:0] ptr_m;
  logic [PTR_W-1:0]   rd_next, hdr_next;
  logic [LEN_W-1:0]   rd_len, hdr_len;

  assign ptr_m    = ptr[MADDR_W-1:0];
  assign rd_next  = mem_rdata[PTR_W-1:0];
  assign rd_len   = mem_rdata[DATA_W-1 -: LEN_W];
  assign hdr_next = hdr[PTR_W-1:0];
  assign hdr_len  = hdr[DATA_W-1 -: LEN_W];
  assign hdr_len_o = rd_len;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_m;
    mem_wdata = hdr;
    unique case (state)
      S_HRD, S_CRD: mem_req = 1'b1;
      S_PRD: begin
        mem_req  = 1'b1;
        mem_addr = paddr;
      end
      S_HWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = hdr | MARK;
      end
      S_CWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = hdr & ~MARK;
      end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  always_comb begin
    state_n  = state;
    ptr_n    = ptr;
    start_n  = start_q;
    hdr_n    = hdr;
    paddr_n  = paddr;
    rem_n    = rem;
    left_n   = left;
    stat_clr = 1'b0;
    hdr_en   = 1'b0;
    node_inc = 1'b0;
    mark_inc = 1'b0;
    loop_set = 1'b0;
    load_out = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ptr_n    = start_addr;
        start_n  = start_addr;
        stat_clr = 1'b1;
        state_n  = S_NEXT;
      end
      S_NEXT: state_n = (ptr == TERM) ? S_CSTART : S_HRD;
      S_HRD:  if (mem_gnt) state_n = S_HWAIT;
      S_HWAIT: if (mem_rvalid) begin
        hdr_n  = mem_rdata;
        hdr_en = 1'b1;
        if (rd_next == TERM) begin
          node_inc = 1'b1;
          ptr_n    = TERM;
          paddr_n  = ptr_m + STEP;
          rem_n    = rd_len;
          state_n  = (rd_len == '0) ? S_NEXT : S_PRD;
        end else if (mem_rdata[MARK_BIT]) begin
          loop_set = 1'b1;
          state_n  = S_CSTART;
        end else begin
          state_n  = S_HWR;
        end
      end
      S_HWR: if (mem_gnt) begin
        node_inc = 1'b1;
        mark_inc = 1'b1;
        ptr_n    = hdr_next;
        paddr_n  = ptr_m + STEP;
        rem_n    = hdr_len;
        state_n  = (hdr_len == '0) ? S_NEXT : S_PRD;
      end
      S_PRD:   if (mem_gnt) state_n = S_PWAIT;
      S_PWAIT: if (mem_rvalid) begin
        load_out = 1'b1;
        state_n  = S_POUT;
      end
      S_POUT: if (out_taken) begin
        rem_n   = rem - 1'b1;
        paddr_n = paddr + STEP;
        state_n = (rem == LEN_W'(1)) ? S_NEXT : S_PRD;
      end
      S_CSTART: begin
        ptr_n   = start_q;
        left_n  = mark_cnt;
        state_n = (mark_cnt == '0) ? S_DONE : S_CRD;
      end
      S_CRD:   if (mem_gnt) state_n = S_CWAIT;
      S_CWAIT: if (mem_rvalid) begin
        hdr_n   = mem_rdata;
        state_n = S_CWR;
      end
      S_CWR: if (mem_gnt) begin
        left_n  = left - 1'b1;
        ptr_n   = PTR_W'(hdr[MADDR_W-1:0]);
        state_n = (left == CNT_W'(1)) ? S_DONE : S_CRD;
      end
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ptr     <= '0;
      start_q <= '0;
      hdr     <= '0;
      paddr   <= '0;
      rem     <= '0;
      left    <= '0;
    end else begin
      state   <= state_n;
      ptr     <= ptr_n;
      start_q <= start_n;
      hdr     <= hdr_n;
      paddr   <= paddr_n;
      rem     <= rem_n;
      left    <= left_n;
    end
  end

endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_walker_pkg::*;
#(
  parameter int unsigned PTR_W    = CW_PTR_W,
  parameter int unsigned MADDR_W  = CW_MADDR_W,
  parameter int unsigned DATA_W   = CW_DATA_W,
  parameter int unsigned LEN_W    = CW_LEN_W,
  parameter int unsigned CNT_W    = CW_CNT_W,
  parameter int unsigned CYC_W    = CW_CYC_W,
  parameter int unsigned CYC_BASE = CW_CYC_BASE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PTR_W-1:0]   start_addr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   node_cnt_o,
  output logic [CYC_W-1:0]   cyc_est_o,
  output logic               loop_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic               mem_gnt_i,
  input  logic               mem_rvalid_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               out_valid_o,
  output logic [DATA_W-1:0]  out_data_o,
  input  logic               out_ready_i
);

  logic             load_out, out_taken;
  logic             stat_clr, hdr_en, node_inc, mark_inc, loop_set;
  logic [LEN_W-1:0] hdr_len;
  logic [CNT_W-1:0] mark_cnt;

  chain_walker_ctrl #(
    .PTR_W(PTR_W), .MADDR_W(MADDR_W), .DATA_W(DATA_W),
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .start_addr (start_addr_i),
    .mem_gnt    (mem_gnt_i),
    .mem_rvalid (mem_rvalid_i),
    .mem_rdata  (mem_rdata_i),
    .out_taken  (out_taken),
    .mark_cnt   (mark_cnt),
    .mem_req    (mem_req_o),
    .mem_we     (mem_we_o),
    .mem_addr   (mem_addr_o),
    .mem_wdata  (mem_wdata_o),
    .load_out   (load_out),
    .stat_clr   (stat_clr),
    .hdr_en     (hdr_en),
    .hdr_len_o  (hdr_len),
    .node_inc   (node_inc),
    .mark_inc   (mark_inc),
    .loop_set   (loop_set),
    .busy       (busy_o),
    .done       (done_o)
  );

  chain_walker_stats #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .CYC_W(CYC_W), .CYC_BASE(CYC_BASE)
  ) stats_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (stat_clr),
    .hdr_en    (hdr_en),
    .hdr_len   (hdr_len),
    .node_inc  (node_inc),
    .mark_inc  (mark_inc),
    .loop_set  (loop_set),
    .node_cnt  (node_cnt_o),
    .mark_cnt  (mark_cnt),
    .cyc_est   (cyc_est_o),
    .loop_flag (loop_o)
  );

  chain_walker_outreg #(.DATA_W(DATA_W)) outreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_out),
    .load_data (mem_rdata_i),
    .ready     (out_ready_i),
    .valid     (out_valid_o),
    .data      (out_data_o),
    .taken     (out_taken)
  );

endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
  parameter int unsigned PTR_W   = chain_walker_pkg::CW_PTR_W,
  parameter int unsigned MADDR_W = chain_walker_pkg::CW_MADDR_W,
  parameter int unsigned DATA_W  = chain_walker_pkg::CW_DATA_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy_o,
  input logic               done_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [MADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0]  mem_wdata_o,
  input logic               mem_gnt_i,
  input logic               mem_rvalid_i,
  input logic [DATA_W-1:0]  mem_rdata_i,
  input logic               out_valid_o,
  input logic [DATA_W-1:0]  out_data_o,
  input logic               out_ready_i
);

  localparam logic [DATA_W-1:0] MARK = DATA_W'(1) << (PTR_W - 1);

  logic               last_was_rd;
  logic [MADDR_W-1:0] last_rd_addr;
  logic [DATA_W-1:0]  last_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_was_rd  <= 1'b0;
      last_rd_addr <= '0;
      last_rd_data <= '0;
    end else begin
      if (mem_req_o && mem_gnt_i) begin
        last_was_rd <= !mem_we_o;
        if (!mem_we_o) last_rd_addr <= mem_addr_o;
      end
      if (mem_rvalid_i) last_rd_data <= mem_rdata_i;
    end
  end

  AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> last_was_rd && (mem_addr_o == last_rd_addr)); // R5
  AST_RMW_MARK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> ((mem_wdata_o ^ last_rd_data) == MARK)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !out_valid_o); // R12

endmodule

bind chain_walker chain_walker_chk #(
  .PTR_W(PTR_W), .MADDR_W(MADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rdata_i  (mem_rdata_i),
  .out_valid_o  (out_valid_o),
  .out_data_o   (out_data_o),
  .out_ready_i  (out_ready_i)
);

// File: tb/chain_walker_tb_top.sv
module chain_walker_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] start_addr_i;
  logic        busy_o, done_o, loop_o;
  logic [19:0] node_cnt_o;
  logic [31:0] cyc_est_o;
  logic        mem_req_o, mem_we_o;
  logic [20:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_gnt_i, mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        out_valid_o, out_ready_i;
  logic [31:0] out_data_o;

  chain_walker dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .busy_o(busy_o), .done_o(done_o), .node_cnt_o(node_cnt_o),
    .cyc_est_o(cyc_est_o), .loop_o(loop_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errs   = 0;

  // memory model: 4096 words, grant stalls one cycle in three, read data one cycle after grant
  logic [31:0] mem [0:4095];
  logic [1:0]  stall_cnt;
  int          n_rd, n_wr, n_bad_addr, n_got;
  logic [31:0] got [0:63];
  logic        bd_we;
  logic [13:0] bd_addr;
  logic [31:0] bd_data;
  logic        rdy_tgl;

  assign mem_gnt_i   = (stall_cnt != 2'd2);
  assign out_ready_i = rdy_tgl;

  always @(posedge clk) begin
    stall_cnt    <= (stall_cnt == 2'd2) ? 2'd0 : stall_cnt + 2'd1;
    rdy_tgl      <= ~rdy_tgl;
    mem_rvalid_i <= 1'b0;
    if (bd_we) begin
      mem[bd_addr[13:2]] <= bd_data;
    end else if (mem_req_o && mem_gnt_i) begin
      if (mem_addr_o[20:14] != 7'd0) n_bad_addr <= n_bad_addr + 1;
      if (mem_we_o) begin
        mem[mem_addr_o[13:2]] <= mem_wdata_o;
        n_wr <= n_wr + 1;
      end else begin
        mem_rdata_i  <= mem[mem_addr_o[13:2]];
        mem_rvalid_i <= 1'b1;
        n_rd <= n_rd + 1;
      end
    end
    if (out_valid_o && out_ready_i) begin
      got[n_got[5:0]] <= out_data_o;
      n_got <= n_got + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  int base_rd, base_wr, base_got;
  logic [19:0] r_cnt;
  logic [31:0] r_cyc;
  logic        r_loop;

  task automatic run(input logic [23:0] a, input bit poke_again);
    base_rd = n_rd; base_wr = n_wr; base_got = n_got;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    if (poke_again) begin
      repeat (4) @(negedge clk);
      start_i = 1'b1; start_addr_i = 24'hFFFFFF;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
    chk("R10 done seen", done_o, 1'b1);
    r_cnt = node_cnt_o; r_cyc = cyc_est_o; r_loop = loop_o;
    @(negedge clk);
    chk("R10 done one cycle", done_o, 1'b0);
    chk("R10 count held", node_cnt_o, r_cnt);
    chk("R10 cost held", cyc_est_o, r_cyc);
  endtask

  task automatic t_reset;
    chk("R12 busy after reset", busy_o, 1'b0);
    chk("R12 done after reset", done_o, 1'b0);
    chk("R12 out_valid after reset", out_valid_o, 1'b0);
    chk("R12 mem_req after reset", mem_req_o, 1'b0);
  endtask

  task automatic t_empty;
    run(24'hFFFFFF, 1'b0);
    chk("R1 empty count", r_cnt, 0);
    chk("R1 empty loop", r_loop, 0);
    chk("R1 empty cost", r_cyc, 0);
    chk("R1 no reads", n_rd - base_rd, 0);
    chk("R1 no writes", n_wr - base_wr, 0);
  endtask

  // nodes at 0x040 (len 2), 0x100 (len 0), 0x200 (len 3, tail); start has bits 23:21 set
  task automatic build_chain;
    poke(14'h040, 32'h02_000100);
    poke(14'h044, 32'hA000_0001);
    poke(14'h048, 32'hA000_0002);
    poke(14'h100, 32'h00_200200);
    poke(14'h200, 32'h03_FFFFFF);
    poke(14'h204, 32'hB000_0001);
    poke(14'h208, 32'hB000_0002);
    poke(14'h20C, 32'hB000_0003);
  endtask

  task automatic check_chain(input string tag);
    logic [31:0] exp_w [0:4];
    exp_w[0] = 32'hA000_0001; exp_w[1] = 32'hA000_0002;
    exp_w[2] = 32'hB000_0001; exp_w[3] = 32'hB000_0002; exp_w[4] = 32'hB000_0003;
    chk({tag, " R4 R6 count"}, r_cnt, 3);
    chk({tag, " R9 cost"}, r_cyc, 20);
    chk({tag, " R7 no loop"}, r_loop, 0);
    chk({tag, " R4 word total"}, n_got - base_got, 5);
    for (int i = 0; i < 5; i++)
      chk({tag, " R3 payload order"}, got[6'(base_got + i)], exp_w[i]);
    chk({tag, " R5 R6 writes"}, n_wr - base_wr, 4);
    chk({tag, " R2 reads"}, n_rd - base_rd, 10);
    chk({tag, " R2 address range"}, n_bad_addr, 0);
    chk({tag, " R8 hdr0 restored"}, mem[12'h010], 32'h02_000100);
    chk({tag, " R8 hdr1 restored"}, mem[12'h040], 32'h00_200200);
    chk({tag, " R6 tail untouched"}, mem[12'h080], 32'h03_FFFFFF);
  endtask

  task automatic t_chain;
    build_chain();
    run(24'hE00040, 1'b0);
    check_chain("chain");
  endtask

  task automatic t_busy_start;
    run(24'hE00040, 1'b1);
    check_chain("R11 restart ignored");
  endtask

  // ring: 0x400 (len 1) -> 0x500 (len 2) -> 0x400
  task automatic t_loop;
    poke(14'h400, 32'h01_000500);
    poke(14'h404, 32'hC000_0001);
    poke(14'h500, 32'h02_000400);
    poke(14'h504, 32'hD000_0001);
    poke(14'h508, 32'hD000_0002);
    run(24'h000400, 1'b0);
    chk("R7 loop flag", r_loop, 1);
    chk("R7 loop count", r_cnt, 2);
    chk("R9 loop cost", r_cyc, 19);
    chk("R7 loop words", n_got - base_got, 3);
    chk("R7 word0", got[6'(base_got)], 32'hC000_0001);
    chk("R7 word2", got[6'(base_got + 2)], 32'hD000_0002);
    chk("R8 ring A restored", mem[12'h100], 32'h01_000500);
    chk("R8 ring B restored", mem[12'h140], 32'h02_000400);
    chk("R12 idle after run", busy_o, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_addr_i = '0;
    bd_we = 1'b0; bd_addr = '0; bd_data = '0;
    stall_cnt = '0; rdy_tgl = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    n_rd = 0; n_wr = 0; n_bad_addr = 0; n_got = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_chain();
    t_busy_start();
    t_loop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

endmodule